// File: doc/BRIEF.md
# Vector Floating-Point Compare Unit

This unit compares two 128-bit vector operands lane by lane. It treats each lane as an IEEE-754 number: four 32-bit single-precision lanes, or two 64-bit double-precision lanes when the precision select is high. For each lane pair the unit finds exactly one of four outcomes: less, equal, greater or unordered. A 5-bit condition code names the set of outcomes that makes a lane true. A true lane returns all ones across the lane and a false lane returns all zeros.

The lowest bit of the condition code chooses the NaN policy. In the quiet policy only a signaling NaN raises invalid-operation. In the signaling policy any NaN raises it. Some code points are reserved, and the unit reports them as an illegal operation. Each accepted strobe gives a new per-operation invalid cause, which is cleared and then rebuilt from all lanes. The same strobe also updates a sticky invalid flag that only reset clears. Results appear one clock after the input strobe, together with an output valid pulse.

Top module: `vec_fp_compare`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `result`, `invalid` and `illegal` change only in the cycle after an accepted strobe, and otherwise hold their values.
- R2: With `dbl_sel`=0, lane k occupies bits [32k+31:32k] (k=0..3). With `dbl_sel`=1, lane k occupies bits [64k+63:64k] (k=0..1). Every lane of `result` is all ones when its relation holds and all zeros when it does not.
- R3: A lane is unordered when either operand is a NaN: exponent all ones and fraction nonzero. +0 and -0 compare equal, denormals are compared as they are, and all other values are ordered by sign and magnitude. Infinities are the extreme values.
- R4: Outcome sets by code (the low bit is ignored here): 0x00 none, 0x02 {lt}, 0x04 {eq}, 0x06 {lt,eq}, 0x08 {un}, 0x0A {un,lt}, 0x0C {un,eq}, 0x0E {un,lt,eq}, 0x10 {lt,gt}, 0x14 {lt,eq,gt}, 0x18 {un,lt,gt}. Each odd code one above these uses the same set.
- R5: With condition bit 0 clear, `invalid` is raised only when an operand in an active lane is a signaling NaN, meaning the fraction's top bit is 0.
- R6: With condition bit 0 set, `invalid` is raised when an operand in an active lane is any NaN.
- R7: Codes 0x12, 0x13, 0x16, 0x17 and 0x1A to 0x1F set `illegal`, give an all-zero `result`, and raise neither `invalid` nor the sticky flag.
- R8: `invalid` is the OR over the lanes of the chosen precision only, and it is recomputed on every operation with no memory of earlier ones.
- R9: `invalid_sticky` becomes set by any operation whose `invalid` is set, and only reset clears it.
- R10: While reset is asserted and right after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| dbl_sel | input | 1 | 1 for double-precision lanes, 0 for single |
| cond | input | 5 | Condition code |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 128 | Lane masks |
| invalid | output | 1 | Invalid-operation cause of the last operation |
| illegal | output | 1 | Last operation used a reserved code |
| invalid_sticky | output | 1 | Accumulated invalid-operation flag |

## Verification
Every output is due exactly one rising edge after the strobe: the lane masks, the invalid cause, the illegal flag and the sticky flag. The bench drives each operation on a falling edge and compares the outputs on the next falling edge. At that point the single register stage has captured the operation and no later strobe has been taken. At idle cycles the bench checks on the same falling-edge grid that `out_valid` has dropped and that the registered values have not moved, even though the inputs have changed.

// File: rtl/vec_fp_compare.sv
module vec_fp_compare #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dbl_sel,
  input  logic [4:0]       cond,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             invalid,
  output logic             illegal,
  output logic             invalid_sticky
);
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;

  function automatic logic is_nan(input logic [63:0] v, input logic d);
    return d ? (&v[62:52] && |v[51:0]) : (&v[30:23] && |v[22:0]);
  endfunction

  function automatic logic is_snan(input logic [63:0] v, input logic d);
    return is_nan(v, d) && !(d ? v[51] : v[22]);
  endfunction

  function automatic logic [62:0] mag(input logic [63:0] v, input logic d);
    return d ? v[62:0] : {32'b0, v[30:0]};
  endfunction

  // outcome one-hot: [0] lt, [1] eq, [2] gt, [3] un
  function automatic logic [3:0] outcome(input logic [63:0] a, input logic [63:0] b,
                                         input logic d);
    logic [62:0] ma, mb;
    logic        sa, sb;
    ma = mag(a, d);
    mb = mag(b, d);
    sa = d ? a[63] : a[31];
    sb = d ? b[63] : b[31];
    if (is_nan(a, d) || is_nan(b, d)) return 4'b1000;
    if (ma == 63'd0 && mb == 63'd0)   return 4'b0010;
    if (sa != sb)                     return sa ? 4'b0001 : 4'b0100;
    if (ma == mb)                     return 4'b0010;
    return ((ma > mb) ^ sa) ? 4'b0100 : 4'b0001;
  endfunction

  wire [3:0] code_hi = cond[4:1];
  wire       legal   = (cond <= 5'h19) && (code_hi != 4'b1001) && (code_hi != 4'b1011);
  wire [3:0] want    = {cond[3], cond[4], cond[2], cond[1] | cond[4]};

  logic [N32-1:0]   hit32, inv32;
  logic [N64-1:0]   hit64, inv64;
  logic [VEC_W-1:0] nxt_result;
  logic             nxt_inv;

  for (genvar i = 0; i < N32; i++) begin : g_sp
    wire [63:0] la = {32'b0, src_a[32*i +: 32]};
    wire [63:0] lb = {32'b0, src_b[32*i +: 32]};
    assign hit32[i] = |(outcome(la, lb, 1'b0) & want);
    assign inv32[i] = cond[0] ? (is_nan(la, 1'b0) || is_nan(lb, 1'b0))
                              : (is_snan(la, 1'b0) || is_snan(lb, 1'b0));
  end

  for (genvar j = 0; j < N64; j++) begin : g_dp
    wire [63:0] la = src_a[64*j +: 64];
    wire [63:0] lb = src_b[64*j +: 64];
    assign hit64[j] = |(outcome(la, lb, 1'b1) & want);
    assign inv64[j] = cond[0] ? (is_nan(la, 1'b1) || is_nan(lb, 1'b1))
                              : (is_snan(la, 1'b1) || is_snan(lb, 1'b1));
  end

  always_comb begin
    for (int k = 0; k < N32; k++)
      nxt_result[32*k +: 32] = {32{legal & (dbl_sel ? hit64[k/2] : hit32[k])}};
  end

  assign nxt_inv = legal & (dbl_sel ? |inv64 : |inv32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      invalid        <= 1'b0;
      illegal        <= 1'b0;
      invalid_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= nxt_result;
        invalid        <= nxt_inv;
        illegal        <= !legal;
        invalid_sticky <= invalid_sticky | nxt_inv;
      end
    end
  end
endmodule

module vec_fp_compare_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             dbl_sel,
  input logic [4:0]       cond,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             invalid,
  input logic             illegal,
  input logic             invalid_sticky
);
  localparam int N32 = VEC_W / 32;

  logic dbl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        dbl_q <= 1'b0;
    else if (in_valid) dbl_q <= dbl_sel;
  end

  logic words_uniform, pairs_match;
  always_comb begin
    words_uniform = 1'b1;
    pairs_match   = 1'b1;
    for (int k = 0; k < N32; k++) begin
      if (result[32*k +: 32] != 32'h0 && result[32*k +: 32] != 32'hFFFF_FFFF)
        words_uniform = 1'b0;
      if (k % 2 == 1 && result[32*k +: 32] != result[32*(k-1) +: 32])
        pairs_match = 1'b0;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(invalid) && $stable(illegal));
  a_r2_lane_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> words_uniform);
  a_r2_double_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dbl_q |-> pairs_match);
  a_r4_never_true: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cond[4:1] == 4'd0 |=> result == '0);
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> result == '0 && !invalid);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_sticky |=> invalid_sticky);
  a_r9_cause_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid |-> invalid_sticky);
endmodule

bind vec_fp_compare vec_fp_compare_chk #(.VEC_W(VEC_W)) chk_i (.*);

// File: tb/vec_fp_compare_tb_top.sv
module vec_fp_compare_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         dbl_sel = 1'b0;
  logic [4:0]   cond = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid, invalid, illegal, invalid_sticky;
  logic [127:0] result;

  int tests = 0;
  int fails = 0;
  logic exp_sticky = 1'b0;

  always #10 clk = ~clk;

  vec_fp_compare dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel), .cond(cond),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .invalid(invalid), .illegal(illegal), .invalid_sticky(invalid_sticky)
  );

  function automatic logic [31:0] sval(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'h7FA0_0000;
      10: return 32'h0000_0001; default: return 32'hFF80_0001;
    endcase
  endfunction

  function automatic logic [63:0] dval(input int i);
    case (i)
      0: return 64'h0;                    1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000;  3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h4000_0000_0000_0000;  5: return 64'hC000_0000_0000_0000;
      6: return 64'h7FF0_0000_0000_0000;  7: return 64'hFFF0_0000_0000_0000;
      8: return 64'h7FF8_0000_0000_0000;  9: return 64'h7FF4_0000_0000_0000;
      10: return 64'h0000_0000_0000_0001; default: return 64'hFFF0_0000_0000_0001;
    endcase
  endfunction

  function automatic logic ref_nan(input logic [63:0] v, input logic d);
    if (d) return v[62:52] == 11'h7FF && v[51:0] != 52'd0;
    return v[30:23] == 8'hFF && v[22:0] != 23'd0;
  endfunction

  function automatic logic ref_snan(input logic [63:0] v, input logic d);
    return ref_nan(v, d) && ((d ? v[51] : v[22]) == 1'b0);
  endfunction

  function automatic logic signed [64:0] ref_key(input logic [63:0] v, input logic d);
    logic [63:0] m;
    logic s;
    m = d ? {1'b0, v[62:0]} : {33'd0, v[30:0]};
    s = d ? v[63] : v[31];
    return s ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

  // bench mask order: [0] lt, [1] eq, [2] gt, [3] un ; [4] legal
  function automatic logic [4:0] ref_mask(input logic [4:0] c);
    case (c >> 1)
      4'h0: return 5'b1_0000;
      4'h1: return 5'b1_0001;
      4'h2: return 5'b1_0010;
      4'h3: return 5'b1_0011;
      4'h4: return 5'b1_1000;
      4'h5: return 5'b1_1001;
      4'h6: return 5'b1_1010;
      4'h7: return 5'b1_1011;
      4'h8: return 5'b1_0101;
      4'hA: return 5'b1_0111;
      4'hC: return 5'b1_1101;
      default: return 5'b0_0000;
    endcase
  endfunction

  function automatic logic ref_lane(input logic [63:0] a, input logic [63:0] b,
                                    input logic d, input logic [3:0] m);
    logic signed [64:0] ka, kb;
    if (ref_nan(a, d) || ref_nan(b, d)) return m[3];
    ka = ref_key(a, d);
    kb = ref_key(b, d);
    if (ka < kb) return m[0];
    if (ka == kb) return m[1];
    return m[2];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one op at a falling edge, check at the next falling edge.
  task automatic run_op(input logic d, input logic [4:0] c, input logic [127:0] a,
                        input logic [127:0] b);
    logic [4:0]   mk;
    logic [127:0] er;
    logic         ei, eil;
    mk = ref_mask(c);
    er = '0;
    ei = 1'b0;
    eil = !mk[4];
    if (d) begin
      for (int k = 0; k < 2; k++) begin
        if (mk[4] && ref_lane(a[64*k +: 64], b[64*k +: 64], 1'b1, mk[3:0]))
          er[64*k +: 64] = '1;
        if (mk[4] && (c[0] ? (ref_nan(a[64*k +: 64], 1'b1) || ref_nan(b[64*k +: 64], 1'b1))
                           : (ref_snan(a[64*k +: 64], 1'b1) || ref_snan(b[64*k +: 64], 1'b1))))
          ei = 1'b1;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (mk[4] && ref_lane({32'd0, a[32*k +: 32]}, {32'd0, b[32*k +: 32]}, 1'b0, mk[3:0]))
          er[32*k +: 32] = '1;
        if (mk[4] && (c[0] ? (ref_nan({32'd0, a[32*k +: 32]}, 1'b0) || ref_nan({32'd0, b[32*k +: 32]}, 1'b0))
                           : (ref_snan({32'd0, a[32*k +: 32]}, 1'b0) || ref_snan({32'd0, b[32*k +: 32]}, 1'b0))))
          ei = 1'b1;
      end
    end
    exp_sticky = exp_sticky | ei;
    dbl_sel = d; cond = c; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1 out_valid", {127'd0, out_valid}, 128'd1);
    check(result == er, eil ? "R7 result" : "R2 R3 R4 result", result, er);
    check(invalid == ei && illegal == eil,
          eil ? "R7 flags" : (c[0] ? "R6 R8 invalid" : "R5 R8 invalid"),
          {126'd0, invalid, illegal}, {126'd0, ei, eil});
    check(invalid_sticky == exp_sticky, "R9 sticky", {127'd0, invalid_sticky},
          {127'd0, exp_sticky});
  endtask

  task automatic idle_check();
    logic [127:0] r0;
    logic i0, l0;
    r0 = result; i0 = invalid; l0 = illegal;
    src_a = ~src_a; src_b = ~src_b; cond = cond ^ 5'h02; dbl_sel = ~dbl_sel;
    @(negedge clk);
    check(out_valid == 1'b0 && result == r0 && invalid == i0 && illegal == l0,
          "R1 hold", result, r0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == '0 && invalid == 0 && illegal == 0 &&
          invalid_sticky == 0, "R10 reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && result == '0 && invalid_sticky == 0, "R10 after reset",
          result, '0);

    // R5: quiet NaN under quiet policy raises nothing; sticky stays clear (R9)
    run_op(1'b0, 5'h04, {4{sval(8)}}, {4{sval(2)}});
    // R8: double mode ignores a lane word that would be a single sNaN
    run_op(1'b1, 5'h04, {2{32'h3FF0_0000, 32'h7FA0_0000}}, {2{64'h3FF0_0000_0000_0000}});
    // R8: sNaN only in the top single lane still raises invalid
    run_op(1'b0, 5'h06, {sval(9), sval(2), sval(2), sval(2)}, {4{sval(4)}});
    // R8: cause cleared by the next clean op
    run_op(1'b0, 5'h06, {4{sval(2)}}, {4{sval(4)}});
    // R7: reserved code with sNaN raises no invalid
    run_op(1'b0, 5'h12, {4{sval(9)}}, {4{sval(9)}});
    idle_check();

    // R3 R4 R5 R6: sweep value pairs and every code in both precisions
    for (int dp = 0; dp < 2; dp++) begin
      for (int ia = 0; ia < 12; ia++) begin
        for (int ib = 0; ib < 12; ib++) begin
          for (int c = 0; c < 32; c++) begin
            logic [127:0] va, vb;
            va = '0; vb = '0;
            if (dp == 1) begin
              for (int k = 0; k < 2; k++) begin
                va[64*k +: 64] = dval((ia + k) % 12);
                vb[64*k +: 64] = dval((ib + 3 * k) % 12);
              end
            end else begin
              for (int k = 0; k < 4; k++) begin
                va[32*k +: 32] = sval((ia + k) % 12);
                vb[32*k +: 32] = sval((ib + 3 * k) % 12);
              end
            end
            run_op(dp[0], c[4:0], va, vb);
          end
        end
        idle_check();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule